// File: doc/BRIEF.md
# Half to Single Precision Widener

This block takes a 16-bit half-precision floating-point value and produces the 32-bit single-precision value that is numerically equal to it. Every half value fits exactly in single precision, so the block does no rounding. It splits the input into sign, 5-bit exponent (bias 15) and 10-bit fraction. It moves normal values onto the wider exponent bias. It shifts subnormal halves left until the leading one is found, which turns them into single-precision normals. Signed zeros, infinities and NaNs keep their sign.

A mode input selects between two encodings of the top exponent value. In standard mode, a half exponent field of 31 means infinity or NaN. In alternative mode, exponent 31 is an ordinary exponent that covers finite values from 65536 up to 131008, and the format has no infinity or NaN.

The conversion logic is combinational. One register stage follows it. A valid strobe on the input produces a valid strobe on the output exactly one clock later, aligned with the converted word.

Top module: `h2s_widen`

## Requirements
- R1: While the active-low reset is asserted, `out_valid` is 0 and `out_single` is 32'h0.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and that cycle carries the converted word. When `in_valid` is low, `out_single` keeps its previous value.
- R3: A half value with exponent field 1..30 (input bits 14:10) converts as follows. The sign (bit 15) is copied to output bit 31. The output exponent (bits 30:23) equals the half exponent plus 112. The half fraction (bits 9:0) goes into output bits 22:13, and bits 12:0 are zero. Examples: 3c00 gives 3f800000, c000 gives c0000000, 7bff gives 477fe000, 0400 gives 38800000.
- R4: A half value whose exponent and fraction are both zero gives a single zero with the same sign: 0000 gives 00000000 and 8000 gives 80000000.
- R5: A half value with exponent zero and a nonzero fraction is subnormal. Let p be the bit position of the leading one in the fraction. The output exponent is 103+p, and the fraction bits below the leading one are left-aligned into output bits 22:0. Examples: 0001 gives 33800000 (2^-24), and 03ff gives 387fc000.
- R6: In standard mode (`alt_mode`=0), exponent 31 with a zero fraction gives a single infinity with the same sign: 7c00 gives 7f800000 and fc00 gives ff800000.
- R7: In standard mode, exponent 31 with a nonzero fraction gives a NaN with the same sign. The output exponent is all ones, the fraction goes into bits 22:13, and bit 22 is forced to 1. Examples: 7c01 gives 7fc02000, and fe00 gives ffc00000.
- R8: In alternative mode (`alt_mode`=1), exponent 31 is a normal exponent and gives output exponent 143. Examples: 7c00 gives 47800000 (65536), and 7fff gives 47ffe000 (131008).
- R9: For every input whose exponent field is not 31, the output does not depend on `alt_mode`. `alt_mode` is sampled in the same cycle as `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_half | input | 16 | Half-precision operand |
| alt_mode | input | 1 | 1 selects the alternative format with no infinity or NaN |
| out_valid | output | 1 | Output word is present this cycle |
| out_single | output | 32 | Single-precision result |

## Verification
Each result is due exactly one rising edge after the cycle that presents it. The bench drives inputs on the falling edge. At the next falling edge it compares the outputs with the expected word for the input it drove in the previous cycle. In a cycle with no input, the bench expects the previously expected word to be held and `out_valid` to be low. A behavioural model computes each expected word from the numeric value of the input, and for subnormals it does this by repeated doubling. A small set of fixed reference conversions is also compared against constants.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
  localparam int HALF_W   = 16;
  localparam int HEXP_W   = 5;
  localparam int HFRAC_W  = 10;
  localparam int SINGLE_W = 32;
  localparam int SEXP_W   = 8;
  localparam int SFRAC_W  = 23;
  localparam int HBIAS    = (1 << (HEXP_W - 1)) - 1;
  localparam int SBIAS    = (1 << (SEXP_W - 1)) - 1;
  localparam int BIAS_ADJ = SBIAS - HBIAS;
  localparam int PAD_W    = SFRAC_W - HFRAC_W;
  localparam int LZ_W     = $clog2(HFRAC_W + 1);

  typedef struct packed {
    logic                sign;
    logic [HEXP_W-1:0]   exp;
    logic [HFRAC_W-1:0]  frac;
  } half_t;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } hclass_e;

  // Rebias a half exponent field onto the single exponent bias.
  function automatic logic [SEXP_W-1:0] rebias(input logic [HEXP_W-1:0] e);
    return {{(SEXP_W-HEXP_W){1'b0}}, e} + SEXP_W'(BIAS_ADJ);
  endfunction

  // Left-align a half fraction inside the single fraction field.
  function automatic logic [SFRAC_W-1:0] align_frac(input logic [HFRAC_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction

  // Exponent of a renormalised subnormal given its leading-zero count.
  function automatic logic [SEXP_W-1:0] sub_exp(input logic [LZ_W-1:0] lz);
    return SEXP_W'(BIAS_ADJ) - {{(SEXP_W-LZ_W){1'b0}}, lz};
  endfunction

  // Fraction bits left below the leading one after renormalisation.
  function automatic logic [HFRAC_W-1:0] sub_frac(input logic [HFRAC_W-1:0] f,
                                                  input logic [LZ_W-1:0] lz);
    logic [HFRAC_W:0] t;
    t = {1'b0, f} << (lz + LZ_W'(1));
    return t[HFRAC_W-1:0];
  endfunction
endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  half_t   h,
  input  logic    alt_mode,
  output hclass_e cls
);
  logic exp_zero, exp_top, frac_zero;

  assign exp_zero  = ~|h.exp;
  assign exp_top   = &h.exp;
  assign frac_zero = ~|h.frac;

  always_comb begin
    if (exp_zero)
      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_top && !alt_mode)
      cls = frac_zero ? CLS_INF : CLS_NAN;
    else
      cls = CLS_NORM;
  end
endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] lz
);
  always_comb begin
    logic found;
    found = 1'b0;
    lz    = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        lz    = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
  import h2s_pkg::*;
(
  input  half_t                 h,
  input  hclass_e               cls,
  input  logic [LZ_W-1:0]       lz,
  output logic [SINGLE_W-1:0]   y
);
  localparam logic [SEXP_W-1:0] EXP_ONES = '1;

  always_comb begin
    unique case (cls)
      CLS_ZERO: y = {h.sign, {(SINGLE_W-1){1'b0}}};
      CLS_SUB:  y = {h.sign, sub_exp(lz), align_frac(sub_frac(h.frac, lz))};
      CLS_INF:  y = {h.sign, EXP_ONES, {SFRAC_W{1'b0}}};
      CLS_NAN:  y = {h.sign, EXP_ONES, 1'b1, h.frac[HFRAC_W-2:0], {PAD_W{1'b0}}};
      default:  y = {h.sign, rebias(h.exp), align_frac(h.frac)};
    endcase
  end
endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
  import h2s_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [HALF_W-1:0]    in_half,
  input  logic                 alt_mode,
  output logic                 out_valid,
  output logic [SINGLE_W-1:0]  out_single
);
  half_t                h;
  hclass_e              cls;
  logic [LZ_W-1:0]      lz;
  logic [SINGLE_W-1:0]  conv;
  logic                 evt_sub;

  assign h       = half_t'(in_half);
  assign evt_sub = in_valid && (cls == CLS_SUB);

  h2s_classify u_cls (.h(h), .alt_mode(alt_mode), .cls(cls));

  h2s_lzc #(.W(HFRAC_W), .CW(LZ_W)) u_lzc (.v(h.frac), .lz(lz));

  h2s_assemble u_asm (.h(h), .cls(cls), .lz(lz), .y(conv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_single <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_single <= conv;
    end
  end
endmodule

// File: rtl/h2s_widen_chk.sv
module h2s_widen_chk
  import h2s_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [HALF_W-1:0]   in_half,
  input logic                alt_mode,
  input logic                out_valid,
  input logic [SINGLE_W-1:0] out_single,
  input logic                evt_sub
);
  logic [HEXP_W-1:0]  ex;
  logic [HFRAC_W-1:0] fr;
  assign ex = in_half[14:10];
  assign fr = in_half[9:0];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_single));
  a_r3_normal_exp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ex != 5'd0 && ex != 5'd31) |=>
      (out_single[30:23] == 8'($past(ex)) + 8'd112) && (out_single[31] == $past(in_half[15])));
  a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half[14:0] == 15'd0) |=> (out_single[30:0] == 31'd0));
  a_r5_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sub |=> (out_single[30:23] >= 8'd103) && (out_single[30:23] <= 8'd112));
  a_r6_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !alt_mode && ex == 5'd31 && fr == 10'd0) |=> (out_single[30:0] == 31'h7f800000));
  a_r7_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !alt_mode && ex == 5'd31 && fr != 10'd0) |=> (out_single[30:22] == 9'h1ff));
  a_r8_alt_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && alt_mode && ex == 5'd31) |=> (out_single[30:23] == 8'h8f));
endmodule

bind h2s_widen h2s_widen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
  .alt_mode(alt_mode), .out_valid(out_valid), .out_single(out_single),
  .evt_sub(evt_sub)
);

// File: tb/test_h2s_widen.sv
module test_h2s_widen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        alt_mode = 1'b0;
  logic        out_valid;
  logic [31:0] out_single;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic        pend_v = 1'b0;
  logic [15:0] pend_h = '0;
  logic        pend_alt = 1'b0;
  logic [31:0] last_exp = '0;

  always #4 clk = ~clk;

  h2s_widen i_h2s_widen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
    .alt_mode(alt_mode), .out_valid(out_valid), .out_single(out_single)
  );

  function automatic logic [31:0] ref_conv(input logic [15:0] hv, input logic alt);
    int e, f, m, se;
    logic s;
    logic [31:0] r;
    s = hv[15];
    e = int'(hv[14:10]);
    f = int'(hv[9:0]);
    if (e == 31 && !alt) begin
      r = {s, 8'hff, 23'd0};
      if (f != 0) r[22:0] = 23'(f * 8192) | 23'h400000;
    end else if (e == 0 && f == 0) begin
      r = {s, 31'd0};
    end else if (e == 0) begin
      m = f; se = -14;
      while (m < 1024) begin m = m * 2; se = se - 1; end
      r = {s, 8'(se + 127), 10'(m - 1024), 13'd0};
    end else begin
      r = {s, 8'(e + 112), 10'(f), 13'd0};
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [15:0] hv, input logic alt);
    if (hv[14:10] == 5'd31)
      return alt ? "R8" : (hv[9:0] == 10'd0 ? "R6" : "R7");
    if (alt) return "R9";
    if (hv[14:10] == 5'd0) return (hv[9:0] == 10'd0) ? "R4" : "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
    end
  endtask

  task automatic stream_check();
    logic [31:0] e;
    chk(out_valid == pend_v, "R2", {31'd0, out_valid}, {31'd0, pend_v});
    if (pend_v) begin
      e = ref_conv(pend_h, pend_alt);
      chk(out_single == e, tag_of(pend_h, pend_alt), out_single, e);
      last_exp = e;
    end else begin
      chk(out_single == last_exp, "R2", out_single, last_exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [15:0] hv, input logic alt);
    @(negedge clk);
    stream_check();
    in_valid = v; in_half = hv; alt_mode = alt;
    pend_v = v; pend_h = hv; pend_alt = alt;
  endtask

  task automatic golden(input logic [15:0] hv, input logic alt, input logic [31:0] expv, input string tag);
    cyc(1'b1, hv, alt);
    cyc(1'b0, 16'h0, ~alt);
    chk(out_single == expv, tag, out_single, expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk(out_valid == 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    chk(out_single == 32'd0, "R1", out_single, 32'd0);
    rst_n = 1'b1;

    golden(16'h3c00, 1'b0, 32'h3f800000, "R3");
    golden(16'hc000, 1'b0, 32'hc0000000, "R3");
    golden(16'h7bff, 1'b0, 32'h477fe000, "R3");
    golden(16'h0400, 1'b0, 32'h38800000, "R3");
    golden(16'h0000, 1'b0, 32'h00000000, "R4");
    golden(16'h8000, 1'b0, 32'h80000000, "R4");
    golden(16'h0001, 1'b0, 32'h33800000, "R5");
    golden(16'h03ff, 1'b0, 32'h387fc000, "R5");
    golden(16'h7c00, 1'b0, 32'h7f800000, "R6");
    golden(16'hfc00, 1'b0, 32'hff800000, "R6");
    golden(16'h7c01, 1'b0, 32'h7fc02000, "R7");
    golden(16'hfe00, 1'b0, 32'hffc00000, "R7");
    golden(16'h7c00, 1'b1, 32'h47800000, "R8");
    golden(16'h7fff, 1'b1, 32'h47ffe000, "R8");
    golden(16'h0001, 1'b1, 32'h33800000, "R9");

    // Exponent sweep in both modes, with idle gaps for the R2 hold check
    for (int a = 0; a < 2; a++)
      for (int e = 0; e < 32; e++)
        for (int k = 0; k < 5; k++) begin
          logic [9:0] fv;
          fv = (k == 0) ? 10'h000 : (k == 1) ? 10'h001 : (k == 2) ? 10'h200 :
               (k == 3) ? 10'h3ff : 10'h155;
          cyc(1'b1, {k[0], 5'(e), fv}, a[0]);
          if (k == 2) cyc(1'b0, 16'hffff, ~a[0]);
        end

    // Every subnormal fraction, alternating sign and mode
    for (int f = 1; f < 1024; f++)
      cyc(1'b1, {f[1], 5'd0, 10'(f)}, f[0]);

    // Every fraction of the top exponent in standard mode
    for (int f = 0; f < 1024; f++)
      cyc(1'b1, {f[2], 5'd31, 10'(f)}, 1'b0);

    cyc(1'b0, 16'h0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule